// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block guards writes to a peripheral's configuration registers. It sits on the register write path in front of the protected registers. It owns two 32-bit key registers, each at its own fixed offset, and each with its own magic word. A protected write is passed on to the register file only while both keys hold their magic words at the same time. At any other time the write is dropped without a trace: nothing reaches the register file, and no error is returned.

Software unlocks the peripheral by writing the two magic words into the two key registers, in either order. It does its configuration writes and then relocks by writing zero to a key. Any value other than the magic word relocks the peripheral in the same way. The key registers themselves can always be written and read back. Reads are never gated.

The write request is a valid/ready channel. The block never applies back-pressure: `wr_ready` is high in every cycle, so a request is consumed in the cycle it is valid. The qualified write leaves on `prot_valid`, `prot_addr` and `prot_data` in that same cycle, with no handshake back from the register file.

A write to a key register changes the lock state from the next cycle on. The lock decision for any write uses the key contents from before that write's clock edge.

Top module: `keylock_top`

## Requirements
- R1: After reset both key registers read as zero and `unlocked` is 0.
- R2: A valid write whose address equals a key offset (key 0 at 0x6C, key 1 at 0x70) stores `wr_data` into that key, visible on `rd_data` from the next cycle, whether locked or not.
- R3: `unlocked` is 1 exactly when key 0 holds 0x83E70B13 and key 1 holds 0x95A4F1E0.
- R4: While `unlocked` is 1, a valid write to any non-key address appears on `prot_valid`/`prot_addr`/`prot_data` in the same cycle with the same address and data.
- R5: While `unlocked` is 0, a valid write to a non-key address is dropped: `prot_valid` stays 0.
- R6: Writing zero, or any value other than its magic word, to either key makes `unlocked` 0 from the next cycle.
- R7: Writes to key addresses never appear on `prot_valid`.
- R8: `wr_ready` is 1 in every cycle, so requests are never stalled.
- R9: `rd_data` returns the addressed key's value regardless of lock state, and reads 0 for any non-key address.
- R10: A single correct key does not unlock, and the two keys may be written in either order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted (always 1) |
| wr_addr | input | ADDR_W (8) | Write byte offset |
| wr_data | input | DATA_W (32) | Write data |
| prot_valid | output | 1 | Qualified write to a protected register |
| prot_addr | output | ADDR_W (8) | Qualified write offset |
| prot_data | output | DATA_W (32) | Qualified write data |
| unlocked | output | 1 | Both keys hold their magic words |
| rd_addr | input | ADDR_W (8) | Key read offset |
| rd_data | output | DATA_W (32) | Key value at `rd_addr`, else 0 |

## Verification
The bench builds the block with its default parameters: 8-bit offsets, 32-bit data, keys at 0x6C and 0x70, and the two 32-bit magic words. With these values it drives the exact offsets and words that software would use. It also reaches the neighbouring offsets 0x60 and 0x7C, which must pass through unguarded by key decoding. The scoreboard predicts each forwarded write from its own model of the keys. It exercises unlock in both orders, relock by zero and by a wrong word, and writes that are dropped while locked.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  localparam int unsigned KEY_COUNT = 2;
  localparam int unsigned KEY_W     = 32;

  typedef logic [KEY_W-1:0] key_word_t;

  localparam key_word_t MAGIC_A = 32'h83E7_0B13;
  localparam key_word_t MAGIC_B = 32'h95A4_F1E0;
endpackage

// File: rtl/keylock_slot.sv
module keylock_slot #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = '0,
  parameter logic [DATA_W-1:0] MAGIC  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic              match,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] word_q;

  assign hit = (wr_addr == OFFSET);

  always_ff @(posedge clk) begin
    if (!rst_n)
      word_q <= '0;
    else if (wr_valid && hit)
      word_q <= wr_data;
  end

  assign value = word_q;
  assign match = (word_q == MAGIC);
endmodule

// File: rtl/keylock_gate.sv
module keylock_gate #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NKEYS  = 2
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NKEYS-1:0]  key_hit,
  input  logic [NKEYS-1:0]  key_match,
  output logic              open,
  output logic              prot_valid,
  output logic [ADDR_W-1:0] prot_addr,
  output logic [DATA_W-1:0] prot_data
);
  // the lock opens only when every slot matches at once
  assign open = &key_match;

  always_comb begin
    prot_valid = wr_valid && open && (key_hit == '0);
    prot_addr  = wr_addr;
    prot_data  = wr_data;
  end
endmodule

// File: rtl/keylock_rdmux.sv
module keylock_rdmux #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NKEYS  = 2,
  parameter logic [NKEYS-1:0][ADDR_W-1:0] OFFSETS = '0
) (
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [NKEYS-1:0][DATA_W-1:0]  values,
  output logic [DATA_W-1:0]             rd_data
);
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NKEYS; k++) begin
      if (rd_addr == OFFSETS[k])
        rd_data = values[k];
    end
  end
endmodule

// File: rtl/keylock_top.sv
module keylock_top
  import keylock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = KEY_W,
  parameter logic [ADDR_W-1:0] KEY_A_OFS = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY_B_OFS = 8'h70,
  parameter logic [DATA_W-1:0] KEY_A_MAGIC = MAGIC_A,
  parameter logic [DATA_W-1:0] KEY_B_MAGIC = MAGIC_B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prot_valid,
  output logic [ADDR_W-1:0] prot_addr,
  output logic [DATA_W-1:0] prot_data,
  output logic              unlocked,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned NK = KEY_COUNT;
  localparam logic [NK-1:0][ADDR_W-1:0] OFS_TAB = {KEY_B_OFS, KEY_A_OFS};
  localparam logic [NK-1:0][DATA_W-1:0] MAG_TAB = {KEY_B_MAGIC, KEY_A_MAGIC};

  logic [NK-1:0]             hit_v;
  logic [NK-1:0]             match_v;
  logic [NK-1:0][DATA_W-1:0] val_v;

  assign wr_ready = 1'b1;

  for (genvar g = 0; g < NK; g++) begin : g_slot
    keylock_slot #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .OFFSET(OFS_TAB[g]), .MAGIC(MAG_TAB[g])
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .hit(hit_v[g]), .match(match_v[g]), .value(val_v[g])
    );
  end

  keylock_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NKEYS(NK)) u_gate (
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_hit(hit_v), .key_match(match_v), .open(unlocked),
    .prot_valid(prot_valid), .prot_addr(prot_addr), .prot_data(prot_data)
  );

  keylock_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NKEYS(NK),
                  .OFFSETS(OFS_TAB)) u_rd (
    .rd_addr(rd_addr), .values(val_v), .rd_data(rd_data)
  );
endmodule

// File: rtl/keylock_chk.sv
module keylock_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_A_OFS = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY_B_OFS = 8'h70,
  parameter logic [DATA_W-1:0] KEY_A_MAGIC = '0,
  parameter logic [DATA_W-1:0] KEY_B_MAGIC = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              prot_valid,
  input logic [ADDR_W-1:0] prot_addr,
  input logic [DATA_W-1:0] prot_data,
  input logic              unlocked
);
  logic is_key;
  assign is_key = (wr_addr == KEY_A_OFS) || (wr_addr == KEY_B_OFS);

  // R5
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_valid |-> unlocked);

  // R7
  key_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_valid |-> (prot_addr != KEY_A_OFS) && (prot_addr != KEY_B_OFS));

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && unlocked && !is_key) |->
      (prot_valid && prot_addr == wr_addr && prot_data == wr_data));

  // R6
  relock_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == KEY_A_OFS && wr_data != KEY_A_MAGIC) |=> !unlocked);

  // R6
  relock_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == KEY_B_OFS && wr_data != KEY_B_MAGIC) |=> !unlocked);

  // R3
  open_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !(wr_valid && is_key)) |=> !unlocked);

  // R8
  never_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_ready);
endmodule

bind keylock_top keylock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .KEY_A_OFS(KEY_A_OFS), .KEY_B_OFS(KEY_B_OFS),
  .KEY_A_MAGIC(KEY_A_MAGIC), .KEY_B_MAGIC(KEY_B_MAGIC)
) u_keylock_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .prot_valid(prot_valid),
  .prot_addr(prot_addr), .prot_data(prot_data), .unlocked(unlocked)
);

// File: tb/keylock_top_test.sv
module keylock_top_test;
  localparam int unsigned PERIOD = 10;
  localparam logic [7:0]  OFS_A = 8'h6C;
  localparam logic [7:0]  OFS_B = 8'h70;
  localparam logic [31:0] MAG_A = 32'h83E7_0B13;
  localparam logic [31:0] MAG_B = 32'h95A4_F1E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        prot_valid;
  logic [7:0]  prot_addr;
  logic [31:0] prot_data;
  logic        unlocked;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] mk_a = '0;
  logic [31:0] mk_b = '0;
  logic [39:0] expq [$];
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  keylock_top uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .prot_valid(prot_valid),
    .prot_addr(prot_addr), .prot_data(prot_data), .unlocked(unlocked),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one write per call; model predicts forwarded items
  task automatic drive_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    if (a == OFS_A) mk_a = d;
    else if (a == OFS_B) mk_b = d;
    else if (mk_a == MAG_A && mk_b == MAG_B) expq.push_back({a, d});
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [7:0] a,
                       input logic [31:0] exp_rd, input logic exp_open);
    @(negedge clk);
    rd_addr = a;
    #(PERIOD/4);
    check({tag, " rd"}, {8'h0, rd_data}, {8'h0, exp_rd});
    check({tag, " lock"}, {39'h0, unlocked}, {39'h0, exp_open});
  endtask

  // monitor: pops expected items as forwarded writes appear
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (prot_valid) begin
        if (expq.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R5/R7: actual=%h expected=none", {prot_addr, prot_data});
        end else begin
          check("R4 forward", {prot_addr, prot_data}, expq.pop_front());
        end
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R8 ready
    probe("R1 keyA", OFS_A, 32'h0, 1'b0);
    probe("R1 keyB", OFS_B, 32'h0, 1'b0);
    check("R8 ready", {39'h0, wr_ready}, 40'h1);
    // R5 dropped while locked
    drive_wr(8'h10, 32'hDEAD_0001);
    // R10 single key: stays locked; R2/R9 read back
    drive_wr(OFS_A, MAG_A);
    probe("R10 one key", OFS_A, MAG_A, 1'b0);
    drive_wr(8'h14, 32'hDEAD_0002);
    drive_wr(OFS_B, MAG_B);
    probe("R3 both keys", OFS_B, MAG_B, 1'b1);
    // R4 forward to several offsets
    drive_wr(8'h00, 32'h1111_2222);
    drive_wr(8'h60, 32'hA5A5_5A5A);
    drive_wr(8'h7C, 32'hFFFF_FFFF);
    // R6 relock by zero
    drive_wr(OFS_B, 32'h0);
    probe("R6 zero", OFS_B, 32'h0, 1'b0);
    drive_wr(8'h20, 32'hDEAD_0003);
    // R6 relock by wrong word; R2 stored while unlocked
    drive_wr(OFS_B, MAG_B);
    probe("R3 again", OFS_A, MAG_A, 1'b1);
    drive_wr(OFS_A, 32'h1234_5678);
    probe("R6 wrong", OFS_A, 32'h1234_5678, 1'b0);
    drive_wr(8'h24, 32'hDEAD_0004);
    // R10 reverse order: B already set, A last
    drive_wr(OFS_A, MAG_A);
    probe("R10 reverse", OFS_A, MAG_A, 1'b1);
    // R7 key rewrite with magic not forwarded
    drive_wr(OFS_A, MAG_A);
    drive_wr(8'h30, 32'hCAFE_F00D);
    // R9 non-key read returns zero
    probe("R9 nonkey", 8'h30, 32'h0, 1'b1);
    repeat (2) @(negedge clk);
    check("R4 drained", {8'h0, 32'(expq.size())}, 40'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule